// File: doc/BRIEF.md
# Configurable Logic-Cell Register Stage

This block is the storage and output stage of one programmable logic cell. It takes the product-term signals produced by an array that lies outside the block. From those terms and a set of static configuration inputs it produces three outputs: the value driven toward the pad, the pad's drive enable, and a feedback bit that returns to the array.

The same register can act as a D, T, JK or SR flip-flop, or as a transparent latch. It can be clocked from the global clock, optionally qualified by an enable term, or from a term of its own. It can be cleared and set by selectable asynchronous sources.

The whole block runs in the global clock domain, `clk`. A product-term clock is taken as an event on the cycle in which that term rises. Clear and preset act on the visible register value at once, and they are also captured into the register at the next edge. `rst_n` is the synchronous active-low reset. It puts the register low, which gives the low state at power-up.

Top module: `mcell_reg_stage`

## Requirements
- R1: After `rst_n` has been low across a rising edge of `clk`, the register holds 0, and with `cfg_out_reg`=1 both `pin_data` and `fb` read 0.
- R2: With `cfg_mode`=0 (D; the codes 5 to 7 also act as D), each active edge loads the data input into the register.
- R3: With `cfg_mode`=1 (T), an active edge with data input 1 inverts the register, and one with data input 0 leaves it unchanged.
- R4: With `cfg_mode`=2 (JK), J is the data input and K is `pt_aux`. The codes behave as follows: J=0,K=0 holds; J=0,K=1 clears; J=1,K=0 sets; J=1,K=1 toggles.
- R5: With `cfg_mode`=3 (SR), S is the data input and R is `pt_aux`. S alone sets, R alone clears, and neither or both hold the value.
- R6: With `cfg_mode`=4 (latch), the data input passes to the register output while the selected clock level is high and is held while it is low. With the global clock, the level is `pt_ce` when `cfg_ce_en`=1 and is always high otherwise.
- R7: With `cfg_ck_sel`=1, the register changes only on cycles in which `pt_clk` was 0 at the previous edge and is 1 now.
- R8: With `cfg_ck_sel`=0 and `cfg_ce_en`=1, edges on which `pt_ce` is 0 are ignored. `pt_ce` has no effect when `cfg_ck_sel`=1.
- R9: The clear source follows `cfg_ar_sel`: 0 is none, 1 is `gclr_n` low, 2 is `pt_ar` high, 3 is either of these. An active clear forces the register output to 0 at once and loads 0 at the edge.
- R10: With `cfg_ap_en`=1, `pt_ap` high forces the register output to 1 at once and loads 1 at the edge, unless a clear is active, in which case the clear wins.
- R11: The path value is (OR of `pt_sum`) XOR p, where `cfg_pol` chooses p as 0 (code 0), 1 (code 1) or `pt_xor` (codes 2 and 3). The register data input is this path value when `cfg_dsel`=0 and `pt_data` when `cfg_dsel`=1.
- R12: With `cfg_out_reg`=1, `pin_data` and `fb` both show the register output. With `cfg_out_reg`=0, `pin_data` shows the path value, and `fb` shows the path value when `cfg_dsel`=0 and the register output when `cfg_dsel`=1.
- R13: `pin_oe` follows `cfg_oe_sel`: 0 is off, 1 is on, 2 is `goe1_n` low, 3 is `goe2_n` low, and 4 to 7 is `pt_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_mode | input | 3 | Register mode code |
| cfg_dsel | input | 1 | Data input: path value (0) or `pt_data` (1) |
| cfg_pol | input | 2 | Second XOR input select |
| cfg_ck_sel | input | 1 | Clock: global (0) or `pt_clk` (1) |
| cfg_ce_en | input | 1 | Use `pt_ce` as enable with the global clock |
| cfg_ar_sel | input | 2 | Clear source select |
| cfg_ap_en | input | 1 | Enable preset from `pt_ap` |
| cfg_out_reg | input | 1 | Pad output registered (1) or combinational (0) |
| cfg_oe_sel | input | 3 | Output enable source select |
| gclr_n | input | 1 | Global clear pin, active low |
| goe1_n | input | 1 | Global enable pin A, active low |
| goe2_n | input | 1 | Global enable pin B, active low |
| pt_sum | input | SUM_W | Terms ORed into the sum |
| pt_xor | input | 1 | Term for the second XOR input |
| pt_data | input | 1 | Dedicated data term |
| pt_aux | input | 1 | K or R term |
| pt_clk | input | 1 | Local clock term |
| pt_ce | input | 1 | Clock enable term |
| pt_ar | input | 1 | Clear term |
| pt_ap | input | 1 | Preset term |
| pt_oe | input | 1 | Output enable term |
| pin_data | output | 1 | Value toward the pad |
| pin_oe | output | 1 | Pad drive enable |
| fb | output | 1 | Buried feedback bit |

## Verification
The bench builds the stage with `SUM_W` at its default of 3. This is wide enough for the OR of several terms to differ from any single term, so the sum and polarity path is exercised on its own. Directed phases step through every mode code, both clock sources with the enable on and off, all clear and preset combinations, and every output and enable select. A seeded random phase then mixes these configurations with random terms, which brings clear/preset overlaps and latch transparency under a term clock into reach.

// File: rtl/mcell_pkg.sv
// Package: shared encodings for the logic-cell register stage.
// Assumes all configuration inputs are static while the cell operates.
package mcell_pkg;
    typedef enum logic [2:0] {
        MODE_D     = 3'd0,
        MODE_T     = 3'd1,
        MODE_JK    = 3'd2,
        MODE_SR    = 3'd3,
        MODE_LATCH = 3'd4
    } reg_mode_e;

    localparam logic [1:0] POL_LOW  = 2'd0;
    localparam logic [1:0] POL_HIGH = 2'd1;

    localparam logic [2:0] OE_OFF  = 3'd0;
    localparam logic [2:0] OE_ON   = 3'd1;
    localparam logic [2:0] OE_PINA = 3'd2;
    localparam logic [2:0] OE_PINB = 3'd3;
endpackage

// File: rtl/mcell_sum_path.sv
// Module: sum and polarity path. ORs the sum terms, then XORs the result
// with a fixed level or a term. Assumes cfg_pol is static.
module mcell_sum_path #(
    parameter int SUM_W = 3
) (
    input  logic [SUM_W-1:0] pt_sum,
    input  logic             pt_xor,
    input  logic [1:0]       cfg_pol,
    output logic             path_out
);
    import mcell_pkg::*;

    logic sum_or;
    logic pol_bit;

    // Purpose: OR reduction and polarity selection.
    always_comb begin
        sum_or = |pt_sum;
        case (cfg_pol)
            POL_LOW:  pol_bit = 1'b0;
            POL_HIGH: pol_bit = 1'b1;
            default:  pol_bit = pt_xor;
        endcase
        path_out = sum_or ^ pol_bit;
    end
endmodule

// File: rtl/mcell_reg_core.sv
// Module: the configurable storage element. Runs on clk only; a term clock
// is taken as the cycle in which pt_clk rises. Clear and preset override the
// visible output at once and load at the edge. Assumes static cfg inputs.
module mcell_reg_core (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cfg_mode,
    input  logic       cfg_ck_sel,
    input  logic       cfg_ce_en,
    input  logic       din,
    input  logic       pt_aux,
    input  logic       pt_clk,
    input  logic       pt_ce,
    input  logic       clr,
    input  logic       pre,
    output logic       q_vis
);
    import mcell_pkg::*;

    logic q_reg;
    logic clk_q;
    logic edge_act;
    logic transp;
    logic is_latch;
    logic nxt;

    // Purpose: decode the active edge and the latch transparency level.
    always_comb begin
        is_latch = (cfg_mode == MODE_LATCH);
        if (cfg_ck_sel) begin
            edge_act = pt_clk & ~clk_q;
            transp   = pt_clk;
        end else begin
            edge_act = cfg_ce_en ? pt_ce : 1'b1;
            transp   = cfg_ce_en ? pt_ce : 1'b1;
        end
    end

    // Purpose: next-state function for each register mode.
    always_comb begin
        nxt = q_reg;
        case (cfg_mode)
            MODE_T:     nxt = q_reg ^ din;
            MODE_JK: begin
                case ({din, pt_aux})
                    2'b01:   nxt = 1'b0;
                    2'b10:   nxt = 1'b1;
                    2'b11:   nxt = ~q_reg;
                    default: nxt = q_reg;
                endcase
            end
            MODE_SR: begin
                case ({din, pt_aux})
                    2'b01:   nxt = 1'b0;
                    2'b10:   nxt = 1'b1;
                    default: nxt = q_reg;
                endcase
            end
            MODE_LATCH: nxt = din;
            default:    nxt = din;
        endcase
    end

    // Purpose: previous level of the term clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_q <= 1'b0;
        else        clk_q <= pt_clk;
    end

    // Purpose: state register with clear over preset over update.
    always_ff @(posedge clk) begin
        if (!rst_n)                          q_reg <= 1'b0;
        else if (clr)                        q_reg <= 1'b0;
        else if (pre)                        q_reg <= 1'b1;
        else if (is_latch ? transp : edge_act) q_reg <= nxt;
    end

    // Purpose: visible register value with overrides and latch pass-through.
    always_comb begin
        if (clr)                    q_vis = 1'b0;
        else if (pre)               q_vis = 1'b1;
        else if (is_latch && transp) q_vis = din;
        else                        q_vis = q_reg;
    end

    p_clear_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !q_reg);
    p_preset_loads_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pre && !clr) |=> q_reg);
    p_no_edge_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_latch && !edge_act && !clr && !pre) |=> $stable(q_reg));
    p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == MODE_T && edge_act && din && !clr && !pre)
        |=> (q_reg != $past(q_reg)));
endmodule

// File: rtl/mcell_out_sel.sv
// Module: pad value, feedback and output-enable selection.
// Assumes the enable pins are already inverted to active high.
module mcell_out_sel (
    input  logic       cfg_out_reg,
    input  logic       cfg_dsel,
    input  logic [2:0] cfg_oe_sel,
    input  logic       q_vis,
    input  logic       path_val,
    input  logic       oe_a,
    input  logic       oe_b,
    input  logic       pt_oe,
    output logic       pin_data,
    output logic       pin_oe,
    output logic       fb
);
    import mcell_pkg::*;

    // Purpose: choose the pad value and the feedback source.
    always_comb begin
        pin_data = cfg_out_reg ? q_vis : path_val;
        fb       = (cfg_out_reg || cfg_dsel) ? q_vis : path_val;
    end

    // Purpose: choose the output enable source.
    always_comb begin
        case (cfg_oe_sel)
            OE_OFF:  pin_oe = 1'b0;
            OE_ON:   pin_oe = 1'b1;
            OE_PINA: pin_oe = oe_a;
            OE_PINB: pin_oe = oe_b;
            default: pin_oe = pt_oe;
        endcase
    end
endmodule

// File: rtl/mcell_reg_stage.sv
// Module: top of the logic-cell register stage. Inverts the active-low
// global pins, decodes clear and preset, and joins the path, the register
// and the output selection. Assumes all cfg_* inputs are static.
module mcell_reg_stage #(
    parameter int SUM_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_mode,
    input  logic             cfg_dsel,
    input  logic [1:0]       cfg_pol,
    input  logic             cfg_ck_sel,
    input  logic             cfg_ce_en,
    input  logic [1:0]       cfg_ar_sel,
    input  logic             cfg_ap_en,
    input  logic             cfg_out_reg,
    input  logic [2:0]       cfg_oe_sel,
    input  logic             gclr_n,
    input  logic             goe1_n,
    input  logic             goe2_n,
    input  logic [SUM_W-1:0] pt_sum,
    input  logic             pt_xor,
    input  logic             pt_data,
    input  logic             pt_aux,
    input  logic             pt_clk,
    input  logic             pt_ce,
    input  logic             pt_ar,
    input  logic             pt_ap,
    input  logic             pt_oe,
    output logic             pin_data,
    output logic             pin_oe,
    output logic             fb
);
    logic path_val;
    logic din;
    logic clr;
    logic pre;
    logic q_vis;
    logic oe_a;
    logic oe_b;

    // Purpose: pin inversion, clear/preset decode and data input choice.
    always_comb begin
        oe_a = ~goe1_n;
        oe_b = ~goe2_n;
        clr  = (cfg_ar_sel[0] & ~gclr_n) | (cfg_ar_sel[1] & pt_ar);
        pre  = cfg_ap_en & pt_ap;
        din  = cfg_dsel ? pt_data : path_val;
    end

    mcell_sum_path #(.SUM_W(SUM_W)) u_path (
        .pt_sum   (pt_sum),
        .pt_xor   (pt_xor),
        .cfg_pol  (cfg_pol),
        .path_out (path_val)
    );

    mcell_reg_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_mode   (cfg_mode),
        .cfg_ck_sel (cfg_ck_sel),
        .cfg_ce_en  (cfg_ce_en),
        .din        (din),
        .pt_aux     (pt_aux),
        .pt_clk     (pt_clk),
        .pt_ce      (pt_ce),
        .clr        (clr),
        .pre        (pre),
        .q_vis      (q_vis)
    );

    mcell_out_sel u_out (
        .cfg_out_reg (cfg_out_reg),
        .cfg_dsel    (cfg_dsel),
        .cfg_oe_sel  (cfg_oe_sel),
        .q_vis       (q_vis),
        .path_val    (path_val),
        .oe_a        (oe_a),
        .oe_b        (oe_b),
        .pt_oe       (pt_oe),
        .pin_data    (pin_data),
        .pin_oe      (pin_oe),
        .fb          (fb)
    );

    p_fb_matches_pin_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_out_reg |-> (fb == pin_data));
    p_oe_pin_a_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_oe_sel == 3'd2) |-> (pin_oe != goe1_n));
    p_clear_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ar_sel[0] && !gclr_n && cfg_out_reg) |-> !pin_data);
endmodule

// File: tb/mcell_reg_stage_tb.sv
`timescale 1ns/1ps
module mcell_reg_stage_tb;
    localparam int SUM_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cfg_mode = 3'd0;
    logic cfg_dsel = 1'b0;
    logic [1:0] cfg_pol = 2'd0;
    logic cfg_ck_sel = 1'b0;
    logic cfg_ce_en = 1'b0;
    logic [1:0] cfg_ar_sel = 2'd0;
    logic cfg_ap_en = 1'b0;
    logic cfg_out_reg = 1'b1;
    logic [2:0] cfg_oe_sel = 3'd1;
    logic gclr_n = 1'b1, goe1_n = 1'b1, goe2_n = 1'b1;
    logic [SUM_W-1:0] pt_sum = '0;
    logic pt_xor = 0, pt_data = 0, pt_aux = 0, pt_clk = 0, pt_ce = 0;
    logic pt_ar = 0, pt_ap = 0, pt_oe = 0;
    logic pin_data, pin_oe, fb;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string tag = "R1";
    int m_q = 0;
    int m_ck = 0;

    always #2 clk = ~clk;

    mcell_reg_stage #(.SUM_W(SUM_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_dsel(cfg_dsel),
        .cfg_pol(cfg_pol), .cfg_ck_sel(cfg_ck_sel), .cfg_ce_en(cfg_ce_en),
        .cfg_ar_sel(cfg_ar_sel), .cfg_ap_en(cfg_ap_en), .cfg_out_reg(cfg_out_reg),
        .cfg_oe_sel(cfg_oe_sel), .gclr_n(gclr_n), .goe1_n(goe1_n), .goe2_n(goe2_n),
        .pt_sum(pt_sum), .pt_xor(pt_xor), .pt_data(pt_data), .pt_aux(pt_aux),
        .pt_clk(pt_clk), .pt_ce(pt_ce), .pt_ar(pt_ar), .pt_ap(pt_ap),
        .pt_oe(pt_oe), .pin_data(pin_data), .pin_oe(pin_oe), .fb(fb)
    );

    // Reference helpers, written from the requirements.
    function automatic int f_path();
        int p;
        if (cfg_pol == 0) p = 0; else if (cfg_pol == 1) p = 1; else p = pt_xor;
        return ((pt_sum != 0) ? 1 : 0) ^ p;
    endfunction
    function automatic int f_din();
        return cfg_dsel ? int'(pt_data) : f_path();
    endfunction
    function automatic int f_clr();
        return ((cfg_ar_sel == 1 || cfg_ar_sel == 3) && !gclr_n) ||
               (cfg_ar_sel >= 2 && pt_ar);
    endfunction
    function automatic int f_pre();
        return cfg_ap_en && pt_ap;
    endfunction
    function automatic int f_level();
        if (cfg_ck_sel) return pt_clk;
        return cfg_ce_en ? int'(pt_ce) : 1;
    endfunction
    function automatic int f_qvis();
        if (f_clr()) return 0;
        if (f_pre()) return 1;
        if (cfg_mode == 4 && f_level()) return f_din();
        return m_q;
    endfunction

    // Reference state update at each edge.
    always @(posedge clk) begin
        int d, k, nq, act;
        if (!rst_n) begin
            m_q = 0; m_ck = 0;
        end else begin
            d = f_din(); k = pt_aux; nq = m_q;
            if (cfg_ck_sel) act = (pt_clk && !m_ck); else act = f_level();
            if (f_clr()) nq = 0;
            else if (f_pre()) nq = 1;
            else if (cfg_mode == 4) begin
                if (f_level()) nq = d;
            end else if (act) begin
                case (cfg_mode)
                    3'd1: nq = m_q ^ d;
                    3'd2: nq = (d && k) ? 1 - m_q : (d ? 1 : (k ? 0 : m_q));
                    3'd3: nq = (d && !k) ? 1 : ((!d && k) ? 0 : m_q);
                    default: nq = d;
                endcase
            end
            m_q = nq;
            m_ck = pt_clk;
        end
    end

    task automatic compare();
        int ed, eo, ef;
        ed = cfg_out_reg ? f_qvis() : f_path();
        ef = (cfg_out_reg || cfg_dsel) ? f_qvis() : f_path();
        case (cfg_oe_sel)
            3'd0: eo = 0;
            3'd1: eo = 1;
            3'd2: eo = !goe1_n;
            3'd3: eo = !goe2_n;
            default: eo = pt_oe;
        endcase
        checks++;
        if (pin_data !== ed[0] || pin_oe !== eo[0] || fb !== ef[0]) begin
            fails++;
            $display("FAIL %s: data/oe/fb = %0b/%0b/%0b expected %0b/%0b/%0b",
                     tag, pin_data, pin_oe, fb, ed[0], eo[0], ef[0]);
        end
    endtask

    // Compare settled outputs, then move to the next driving point.
    task automatic step();
        #1 compare();
        @(negedge clk);
    endtask

    task automatic rand_terms();
        pt_sum = SUM_W'($urandom); pt_xor = 1'($urandom); pt_data = 1'($urandom);
        pt_aux = 1'($urandom); pt_clk = 1'($urandom); pt_ce = 1'($urandom);
        pt_oe = 1'($urandom); goe1_n = 1'($urandom); goe2_n = 1'($urandom);
    endtask

    task automatic quiet();
        pt_ar = 0; pt_ap = 0; gclr_n = 1;
    endtask

    initial begin
        void'($urandom(32'h5eed));
        @(negedge clk);
        // R1: reset drives the register low
        tag = "R1";
        pt_sum = '1; cfg_out_reg = 1;
        repeat (3) step();
        rst_n = 1; step();
        // R2: D mode
        tag = "R2"; cfg_mode = 0;
        for (int i = 0; i < 16; i++) begin rand_terms(); step(); end
        // R3: T mode
        tag = "R3"; cfg_mode = 1;
        for (int i = 0; i < 16; i++) begin rand_terms(); step(); end
        // R4: JK mode, all four codes
        tag = "R4"; cfg_mode = 2; cfg_dsel = 1;
        for (int i = 0; i < 16; i++) begin pt_data = i[0]; pt_aux = i[1]; step(); end
        // R5: SR mode
        tag = "R5"; cfg_mode = 3;
        for (int i = 0; i < 16; i++) begin pt_data = i[1]; pt_aux = i[2]; step(); end
        // R6: latch under global clock with enable level
        tag = "R6"; cfg_mode = 4; cfg_ce_en = 1;
        for (int i = 0; i < 16; i++) begin pt_ce = i[1]; pt_data = i[0]; step(); end
        // R7: term clock edges, D mode
        tag = "R7"; cfg_mode = 0; cfg_ce_en = 0; cfg_ck_sel = 1;
        for (int i = 0; i < 24; i++) begin pt_clk = i[1]; pt_data = i[0] ^ i[2]; step(); end
        // R8: enable with global clock, then enable ignored with term clock
        tag = "R8"; cfg_ck_sel = 0; cfg_ce_en = 1;
        for (int i = 0; i < 16; i++) begin pt_ce = i[2]; pt_data = i[0]; step(); end
        cfg_ck_sel = 1; pt_ce = 0;
        for (int i = 0; i < 16; i++) begin pt_clk = i[1]; pt_data = i[2]; step(); end
        cfg_ck_sel = 0; cfg_ce_en = 0;
        // R9: every clear source select
        tag = "R9"; cfg_mode = 0; pt_data = 1;
        for (int s = 0; s < 4; s++) begin
            cfg_ar_sel = 2'(s);
            for (int i = 0; i < 8; i++) begin gclr_n = !i[0]; pt_ar = i[1]; step(); end
        end
        quiet();
        // R10: preset and clear overlap
        tag = "R10"; cfg_ap_en = 1; cfg_ar_sel = 3; pt_data = 0;
        for (int i = 0; i < 16; i++) begin pt_ap = i[0]; pt_ar = i[1]; gclr_n = !i[3]; step(); end
        quiet(); cfg_ap_en = 0; cfg_ar_sel = 0;
        // R11: polarity and data select
        tag = "R11"; cfg_dsel = 0;
        for (int p = 0; p < 4; p++) begin
            cfg_pol = 2'(p);
            for (int i = 0; i < 8; i++) begin rand_terms(); step(); end
        end
        // R12: combinational output and feedback choice
        tag = "R12"; cfg_out_reg = 0;
        for (int i = 0; i < 16; i++) begin cfg_dsel = i[2]; rand_terms(); step(); end
        cfg_out_reg = 1;
        // R13: all enable selects
        tag = "R13";
        for (int s = 0; s < 8; s++) begin
            cfg_oe_sel = 3'(s);
            for (int i = 0; i < 4; i++) begin rand_terms(); step(); end
        end
        // Mixed random configurations across all requirements (R2 tag)
        tag = "R2";
        for (int c = 0; c < 250; c++) begin
            cfg_mode = 3'($urandom); cfg_dsel = 1'($urandom); cfg_pol = 2'($urandom);
            cfg_ck_sel = 1'($urandom); cfg_ce_en = 1'($urandom);
            cfg_ar_sel = 2'($urandom); cfg_ap_en = 1'($urandom);
            cfg_out_reg = 1'($urandom); cfg_oe_sel = 3'($urandom);
            for (int i = 0; i < 8; i++) begin
                rand_terms();
                pt_ar = ($urandom % 8) == 0; pt_ap = ($urandom % 6) == 0;
                gclr_n = ($urandom % 8) != 0;
                step();
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule